// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on unrelated clocks. The write side shows a full flag and an almost-full flag. The read side shows an empty flag and an almost-empty flag. All four flags are active low. The two thresholds are set by offsets held in four 9-bit registers. Software-free setup is possible: the registers take default values at reset and can also be rewritten through the ordinary write data bus.

The level of `wr_en2_ld_n` while `rst` is high decides what that pin does after reset. If it is held high, the pin becomes a second active-low write enable. If it is held low, the pin becomes a load strobe for the offset registers. Both sides have two active-low enables, so several buffers can be placed side by side to build a wider word. The read data leaves through an output register and is forced to zero unless the output enable is low.

The pointers cross between the two clock domains as Gray code through two-flop synchronizers. A flag is therefore raised at once in the domain that owns it, and released only after the pointer from the other side has crossed.

Top module: `dcfifo_progflag`

## Requirements
- R1: While `rst` is high, and on the first edge of each clock after it falls, the flags hold these values: `empty_n` low, `almost_empty_n` low, `full_n` high and `almost_full_n` high. Reset also empties the buffer, sets both offsets to 7 and points the load rotation at its first register.
- R2: The level of `wr_en2_ld_n` during reset selects its role. High means it acts as a second write enable. Low means it acts as the offset load strobe. In load mode, a cycle with both `wr_en1_n` and `wr_en2_ld_n` low adds no word to the buffer.
- R3: In second-enable mode, a word is stored on a `wr_clk` edge only when both write enables are low and `full_n` is high. In load mode, a word is stored only when `wr_en1_n` is low, `wr_en2_ld_n` is high and `full_n` is high. Any other write attempt, including one made while full, changes nothing.
- R4: A word is taken on an `rd_clk` edge only when `rd_en1_n` and `rd_en2_n` are both low and `empty_n` is high. A read attempt while empty, or with either read enable high, leaves `rd_data` and the buffer contents unchanged.
- R5: In load mode, each `wr_clk` edge with `wr_en1_n` and `wr_en2_ld_n` both low copies `wr_data` into the next offset register. The order is: empty-offset low half, empty-offset high half, full-offset low half, full-offset high half. The fifth load wraps back to the empty-offset low half. Each offset is {high half, low half}, and any value of at least 2^(ADDR_W+1) saturates.
- R6: Once settled, `almost_full_n` is low exactly when the stored word count is at least DEPTH minus m, where m is the full offset.
- R7: Once settled, `almost_empty_n` is low exactly when the stored word count is at most n, where n is the empty offset.
- R8: Words leave in the order they were written. A word appears on `rd_data` on the `rd_clk` edge that accepts the read, so the first word can be taken on the read cycle after `empty_n` rises.
- R9: While `rd_oe_n` is high, `rd_data` is all zeros.
- R10: `empty_n` is low in every read cycle in which the buffer holds no word. `full_n` is low in every write cycle in which it holds DEPTH words. Once settled, both are high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en1_n | input | 1 | First write enable, active low |
| wr_en2_ld_n | input | 1 | Second write enable or offset load strobe; role chosen during reset |
| wr_data | input | DATA_W | Write word, also the offset load value |
| full_n | output | 1 | Low when the buffer is full (write domain) |
| almost_full_n | output | 1 | Low when the word count reaches DEPTH minus m (write domain) |
| rd_clk | input | 1 | Read-side clock |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W | Read word, zero while output is disabled |
| empty_n | output | 1 | Low when the buffer is empty (read domain) |
| almost_empty_n | output | 1 | Low when the word count is at most n (read domain) |

## Verification
The bench pushes the count across each threshold one word at a time: from n to n+1 and from DEPTH-m-1 to DEPTH-m. An off-by-one in either comparison therefore shows up as a flag that is wrong at exactly one count. It keeps writing while full and reading while empty. A design that let either attempt through would repeat or lose a word, and the model comparison at the next read would catch it. It loads five offsets so that the last load has to wrap onto the empty-offset low half. A rotation that did not wrap, or wrapped to the wrong register, leaves a different n and moves the almost-empty edge. It also drives a single low enable in both modes, which exposes a design that decodes the dual-role pin wrongly.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {
    MODE_SECOND_EN = 1'b0,
    MODE_LOAD      = 1'b1
  } wr_pin_mode_e;
endpackage

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= gray_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  // Gray to binary: each bit is the XOR of all gray bits at or above it
  always_comb begin
    bin_out[W-1] = stage_q[STAGES-1][W-1];
    for (int i = W-2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stage_q[STAGES-1][i];
  end
endmodule

// File: rtl/dcf_dpram.sv
module dcf_dpram #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_offset_regs.sv
module dcf_offset_regs #(
  parameter int DATA_W   = 9,
  parameter int PTR_W    = 7,
  parameter int DFLT_OFS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_stb,
  input  logic [DATA_W-1:0] din,
  output logic [PTR_W-1:0]  empty_ofs,
  output logic [PTR_W-1:0]  full_ofs
);
  localparam int NREG = 4;
  localparam int WIDE = 2 * DATA_W;

  logic [DATA_W-1:0] reg_q [NREG];
  logic [1:0]        slot_q;
  logic [WIDE-1:0]   wide_ofs [2];
  logic [PTR_W-1:0]  sat_ofs  [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      for (int r = 0; r < NREG; r++)
        reg_q[r] <= (r % 2 == 0) ? DATA_W'(DFLT_OFS) : '0;
    end else if (ld_stb) begin
      reg_q[slot_q] <= din;
      slot_q        <= slot_q + 2'd1;
    end
  end

  // Slots 0/1 form the empty offset, slots 2/3 the full offset
  for (genvar k = 0; k < 2; k++) begin : g_join
    assign wide_ofs[k] = {reg_q[2*k+1], reg_q[2*k]};
    assign sat_ofs[k]  = (|wide_ofs[k][WIDE-1:PTR_W]) ? '1 : wide_ofs[k][PTR_W-1:0];
  end

  assign empty_ofs = sat_ofs[0];
  assign full_ofs  = sat_ofs[1];
endmodule

// File: rtl/dcfifo_progflag.sv
module dcfifo_progflag
  import dcfifo_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int ADDR_W   = 6,
  parameter int DFLT_OFS = 7
) (
  input  logic              rst,
  input  logic              wr_clk,
  input  logic              wr_en1_n,
  input  logic              wr_en2_ld_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_n,
  output logic              almost_full_n,
  input  logic              rd_clk,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              rd_oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              almost_empty_n
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int CNT_W = PTR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  wr_pin_mode_e     pin_mode_q;
  logic             wr_go, ld_go, rd_go;
  logic [PTR_W-1:0] wbin_q, wgray_q, wbin_nx, rbin_ws, wcnt_nx;
  logic [PTR_W-1:0] rbin_q, rgray_q, rbin_nx, wbin_rs, rcnt_nx;
  logic [PTR_W-1:0] empty_ofs, full_ofs;
  logic [DATA_W-1:0] ram_q;

  // ---------------- write domain ----------------
  always_ff @(posedge wr_clk) begin
    if (rst) pin_mode_q <= wr_en2_ld_n ? MODE_SECOND_EN : MODE_LOAD;
  end

  always_comb begin
    wr_go = 1'b0;
    ld_go = 1'b0;
    if (!rst && !wr_en1_n) begin
      if (pin_mode_q == MODE_SECOND_EN) begin
        wr_go = !wr_en2_ld_n && full_n;
      end else begin
        wr_go = wr_en2_ld_n && full_n;
        ld_go = !wr_en2_ld_n;
      end
    end
  end

  assign wbin_nx = wbin_q + PTR_W'(wr_go);
  assign wcnt_nx = wbin_nx - rbin_ws;

  always_ff @(posedge wr_clk) begin
    if (rst) begin
      wbin_q        <= '0;
      wgray_q       <= '0;
      full_n        <= 1'b1;
      almost_full_n <= 1'b1;
    end else begin
      wbin_q        <= wbin_nx;
      wgray_q       <= wbin_nx ^ (wbin_nx >> 1);
      full_n        <= wcnt_nx != PTR_W'(DEPTH);
      almost_full_n <= ({1'b0, wcnt_nx} + {1'b0, full_ofs}) < CNT_W'(DEPTH);
    end
  end

  dcf_offset_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W), .DFLT_OFS(DFLT_OFS)) ofs_i (
    .clk(wr_clk), .rst(rst), .ld_stb(ld_go), .din(wr_data),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  dcf_ptr_sync #(.W(PTR_W)) rptr_to_wr_i (
    .clk(wr_clk), .rst(rst), .gray_in(rgray_q), .bin_out(rbin_ws)
  );

  // ---------------- storage ----------------
  dcf_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .wr_clk(wr_clk), .we(wr_go), .waddr(wbin_q[ADDR_W-1:0]), .wdata(wr_data),
    .rd_clk(rd_clk), .rst(rst), .re(rd_go), .raddr(rbin_q[ADDR_W-1:0]), .rdata(ram_q)
  );

  // ---------------- read domain ----------------
  assign rd_go   = !rst && !rd_en1_n && !rd_en2_n && empty_n;
  assign rbin_nx = rbin_q + PTR_W'(rd_go);
  assign rcnt_nx = wbin_rs - rbin_nx;

  always_ff @(posedge rd_clk) begin
    if (rst) begin
      rbin_q         <= '0;
      rgray_q        <= '0;
      empty_n        <= 1'b0;
      almost_empty_n <= 1'b0;
    end else begin
      rbin_q         <= rbin_nx;
      rgray_q        <= rbin_nx ^ (rbin_nx >> 1);
      empty_n        <= rcnt_nx != '0;
      almost_empty_n <= rcnt_nx > empty_ofs;
    end
  end

  dcf_ptr_sync #(.W(PTR_W)) wptr_to_rd_i (
    .clk(rd_clk), .rst(rst), .gray_in(wgray_q), .bin_out(wbin_rs)
  );

  assign rd_data = rd_oe_n ? '0 : ram_q;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int DATA_W = 9,
  parameter int PTR_W  = 7
) (
  input logic              rst,
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              full_n,
  input logic              almost_full_n,
  input logic              empty_n,
  input logic              almost_empty_n,
  input logic              rd_oe_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [PTR_W-1:0]  wptr,
  input logic [PTR_W-1:0]  rptr
);
  assert_reset_wr_R1: assert property (@(posedge wr_clk)
    rst |=> (full_n && almost_full_n));

  assert_reset_rd_R1: assert property (@(posedge rd_clk)
    rst |=> (!empty_n && !almost_empty_n));

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (rst)
    !full_n |=> (wptr == $past(wptr)));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (rst)
    !empty_n |=> (rptr == $past(rptr)));

  assert_full_within_af_R6: assert property (@(posedge wr_clk) disable iff (rst)
    !full_n |-> !almost_full_n);

  assert_empty_within_ae_R7: assert property (@(posedge rd_clk) disable iff (rst)
    !empty_n |-> !almost_empty_n);

  assert_oe_zero_R9: assert property (@(posedge rd_clk) disable iff (rst)
    rd_oe_n |-> (rd_data == '0));
endmodule

bind dcfifo_progflag dcf_chk #(.DATA_W(DATA_W), .PTR_W(ADDR_W + 1)) chk_i (
  .rst(rst), .wr_clk(wr_clk), .rd_clk(rd_clk),
  .full_n(full_n), .almost_full_n(almost_full_n),
  .empty_n(empty_n), .almost_empty_n(almost_empty_n),
  .rd_oe_n(rd_oe_n), .rd_data(rd_data),
  .wptr(wbin_q), .rptr(rbin_q)
);

// File: tb/dcfifo_progflag_tb_top.sv
`timescale 1ns/100ps
module dcfifo_progflag_tb_top;
  localparam int DEPTH = 64;

  logic rst = 1'b1;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en1_n = 1'b1, wr_en2_ld_n = 1'b1;
  logic [8:0] wr_data = '0;
  logic rd_en1_n = 1'b1, rd_en2_n = 1'b1, rd_oe_n = 1'b1;
  logic full_n, almost_full_n, empty_n, almost_empty_n;
  logic [8:0] rd_data;

  int vectors = 0, errors = 0;
  logic [8:0] q[$];
  logic [8:0] last_rd = '0;
  int ofs[4];
  int lidx = 0;
  bit mode_load = 0;

  always #4   wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  dcfifo_progflag dut_i (
    .rst(rst), .wr_clk(wr_clk), .wr_en1_n(wr_en1_n), .wr_en2_ld_n(wr_en2_ld_n),
    .wr_data(wr_data), .full_n(full_n), .almost_full_n(almost_full_n),
    .rd_clk(rd_clk), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .rd_oe_n(rd_oe_n),
    .rd_data(rd_data), .empty_n(empty_n), .almost_empty_n(almost_empty_n)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison of the hard flags against the model (R10)
  always @(negedge rd_clk) if (!rst && q.size() == 0) check("R10 empty", int'(empty_n), 0);
  always @(negedge wr_clk) if (!rst && q.size() == DEPTH) check("R10 full", int'(full_n), 0);

  task automatic do_reset(input logic pin);
    rst = 1'b1; wr_en1_n = 1'b1; wr_en2_ld_n = pin;
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    repeat (5) @(posedge rd_clk);
    q.delete(); last_rd = '0; lidx = 0; mode_load = !pin;
    ofs[0] = 7; ofs[1] = 0; ofs[2] = 7; ofs[3] = 0;
    @(negedge wr_clk); rst = 1'b0; wr_en2_ld_n = 1'b1;
    repeat (3) @(posedge rd_clk);
  endtask

  task automatic wr_cycle(input logic e1, input logic pin, input logic [8:0] d);
    bit acc, ld;
    @(negedge wr_clk);
    acc = full_n && !e1 && (mode_load ? pin : !pin);
    ld  = mode_load && !e1 && !pin;
    wr_en1_n = e1; wr_en2_ld_n = pin; wr_data = d;
    @(posedge wr_clk);
    if (acc) q.push_back(d);
    if (ld) begin ofs[lidx] = int'(d); lidx = (lidx + 1) % 4; end
    #1; wr_en1_n = 1'b1; wr_en2_ld_n = 1'b1;
  endtask

  task automatic put(input logic [8:0] d);
    wr_cycle(1'b0, mode_load ? 1'b1 : 1'b0, d);
  endtask

  task automatic rd_cycle(input logic e1, input logic e2);
    bit acc;
    @(negedge rd_clk);
    acc = empty_n && !e1 && !e2;
    rd_en1_n = e1; rd_en2_n = e2;
    @(posedge rd_clk);
    if (acc) last_rd = q.pop_front();
    #1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    @(negedge rd_clk);
    if (!rd_oe_n) check(acc ? "R8 data order" : "R4 ignored read", int'(rd_data), int'(last_rd));
  endtask

  task automatic settle_flags();
    int cnt, n, m;
    repeat (6) @(posedge wr_clk);
    repeat (6) @(posedge rd_clk);
    cnt = q.size();
    n = ofs[1] * 512 + ofs[0];
    m = ofs[3] * 512 + ofs[2];
    @(negedge rd_clk);
    check("R10 empty_n settled", int'(empty_n), (cnt != 0) ? 1 : 0);
    check("R7 almost_empty_n", int'(almost_empty_n), (cnt <= n) ? 0 : 1);
    @(negedge wr_clk);
    check("R10 full_n settled", int'(full_n), (cnt != DEPTH) ? 1 : 0);
    check("R6 almost_full_n", int'(almost_full_n), (cnt + m >= DEPTH) ? 0 : 1);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++; vectors++;
    $display("FAIL all requirements: watchdog expired, actual 1 expected 0");
    finish_run();
  end

  initial begin
    // R1: reset state, R9: output disabled
    rst = 1'b1; wr_en2_ld_n = 1'b1;
    repeat (4) @(posedge rd_clk);
    @(negedge rd_clk);
    check("R1 empty_n in reset", int'(empty_n), 0);
    check("R1 almost_empty_n in reset", int'(almost_empty_n), 0);
    check("R9 rd_data with oe off", int'(rd_data), 0);
    @(negedge wr_clk);
    check("R1 full_n in reset", int'(full_n), 1);
    check("R1 almost_full_n in reset", int'(almost_full_n), 1);

    // ---- second-enable mode (R2, R3) ----
    do_reset(1'b1);
    rd_oe_n = 1'b0;
    settle_flags();
    for (int i = 0; i < 10; i++) put(9'(i * 37 + 11));
    settle_flags();                                  // 10 words: above n=7
    for (int i = 0; i < 3; i++) rd_cycle(1'b0, 1'b0);
    settle_flags();                                  // 7 words: at n, R7
    wr_cycle(1'b0, 1'b1, 9'h1AA);                    // R2/R3: one enable only
    wr_cycle(1'b1, 1'b0, 9'h1AB);
    rd_cycle(1'b0, 1'b1);                            // R4: one read enable high
    rd_cycle(1'b1, 1'b0);
    settle_flags();
    for (int i = 0; i < 49; i++) put(9'(i * 13 + 5));
    settle_flags();                                  // 56: one below DEPTH-m, R6
    put(9'h0F0);
    settle_flags();                                  // 57: at DEPTH-m
    for (int i = 0; i < 7; i++) put(9'(i * 71 + 3));
    wr_cycle(1'b0, 1'b0, 9'h155);                    // R3: writes while full
    wr_cycle(1'b0, 1'b0, 9'h0AA);
    settle_flags();
    rd_oe_n = 1'b1;                                  // R9
    @(negedge rd_clk); check("R9 rd_data with oe off", int'(rd_data), 0);
    rd_oe_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) rd_cycle(1'b0, 1'b0);
    rd_cycle(1'b0, 1'b0);                            // R4: reads while empty
    rd_cycle(1'b0, 1'b0);
    put(9'h123);
    settle_flags();
    rd_cycle(1'b0, 1'b0);                            // R8: pointers intact
    settle_flags();

    // ---- load mode (R2, R5) ----
    do_reset(1'b0);
    wr_cycle(1'b0, 1'b0, 9'd3);                      // empty low
    wr_cycle(1'b0, 1'b0, 9'd0);                      // empty high
    wr_cycle(1'b0, 1'b0, 9'd5);                      // full low
    wr_cycle(1'b0, 1'b0, 9'd0);                      // full high
    wr_cycle(1'b0, 1'b0, 9'd4);                      // R5 wrap: empty low again
    settle_flags();                                  // R2: loads stored no word
    for (int i = 0; i < 4; i++) put(9'(i * 29 + 1));
    settle_flags();                                  // R5/R7: 4 <= n=4
    put(9'h077);
    settle_flags();                                  // 5 > n
    for (int i = 0; i < 53; i++) put(9'(i * 17 + 9));
    settle_flags();                                  // R5/R6: 58 below 64-5
    put(9'h1E1);
    settle_flags();                                  // 59 at 64-5
    for (int i = 0; i < 59; i++) rd_cycle(1'b0, 1'b0);
    settle_flags();
    finish_run();
  end
endmodule